// File: doc/BRIEF.md
# Segment Select and Linear Address Unit

This unit sits between address generation and the memory path. For each memory reference it decides which of six segment registers applies and adds that segment's base to a 32-bit offset, giving the linear address. The implicit choice follows from the kind of reference: code fetches go through the code segment, implicit push and pop operations through the stack segment, and ordinary data through the data segment. A decoded prefix field may name another segment for data references, and this is the only way to reach the three extra segments.

Bases are loaded through a simple write port, one per clock. Reset clears every base, so the unit starts in flat mode, where the linear address equals the offset across the full 4 GiB space. Bases may overlap freely. The result is registered: the chosen segment code, its base and the linear address appear one cycle after a request, together with a valid strobe.

Segment codes on every port are: 0 extra segment (ES), 1 code (CS), 2 stack (SS), 3 data (DS), 4 extra F (FS), 5 extra G (GS). Reference kinds on `req_kind` are: 0 data, 1 implicit push/pop, 2 instruction fetch, 3 stack-relative data.

Top module: `seg_linear_unit`

## Requirements
- R1: After reset, `out_valid` is 0 and all six bases are 0.
- R2: A data reference (kind 0) with no override uses segment code 3 (DS).
- R3: An implicit push/pop (kind 1) always uses code 2 (SS); the override field has no effect.
- R4: An instruction fetch (kind 2) always uses code 1 (CS); the override field has no effect.
- R5: A stack-relative data reference (kind 3) with no override uses code 2 (SS).
- R6: For kinds 0 and 3, an override code 0 to 5 selects that segment instead of the default; codes 6 and 7 mean no override. Codes 0, 4 and 5 are reachable only this way.
- R7: `out_linear` equals the selected base plus the offset, modulo 2^32, with the carry dropped.
- R8: `out_valid` is 1 exactly in the cycle after a cycle with `req_valid` high; `out_seg`, `out_base` and `out_linear` change only then and hold otherwise.
- R9: With `wr_en` high, the base named by `wr_idx` takes `wr_base` at the clock edge; a reference in the same cycle sees the previous value; `wr_idx` 6 or 7 changes no base.
- R10: With all bases zero, `out_linear` equals the request offset and `out_base` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Reference request strobe |
| req_kind | input | 2 | Reference kind (0 data, 1 push/pop, 2 fetch, 3 stack-relative) |
| req_ovr | input | 3 | Decoded override code; 6 or 7 means none |
| req_offset | input | 32 | Effective offset, instruction pointer for fetches |
| wr_en | input | 1 | Base write enable |
| wr_idx | input | 3 | Segment code of base to write |
| wr_base | input | 32 | New base value |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_seg | output | 3 | Selected segment code |
| out_base | output | 32 | Base of the selected segment |
| out_linear | output | 32 | Linear address |

## Verification
A base write and a reference to that same segment can land in the same cycle, and the reference must then see the old base while the next reference sees the new one. The bench drives this collision directly, for the code, stack and an override-only segment, and also lets it arise in random traffic, where the write index and the override code are drawn from small ranges so that they often coincide. Each result is judged against a bench model that computes the expected address from its base copy before applying the write.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int ADDR_W   = 32;
    localparam int IDX_W    = 3;
    localparam int NUM_SEGS = 6;

    typedef enum logic [IDX_W-1:0] {
        SEG_ES = 3'd0,
        SEG_CS = 3'd1,
        SEG_SS = 3'd2,
        SEG_DS = 3'd3,
        SEG_FS = 3'd4,
        SEG_GS = 3'd5
    } seg_e;

    typedef enum logic [1:0] {
        REF_DATA    = 2'd0,
        REF_PUSHPOP = 2'd1,
        REF_FETCH   = 2'd2,
        REF_STKDATA = 2'd3
    } ref_e;

    typedef struct packed {
        logic                    valid;
        seg_e                    seg;
        logic [ADDR_W-1:0]       base;
        logic [ADDR_W-1:0]       linear;
    } addr_res_t;

    // An override code names a real segment only below NUM_SEGS.
    function automatic logic ovr_usable(input logic [IDX_W-1:0] code);
        return code <= IDX_W'(NUM_SEGS - 1);
    endfunction

    // Implicit choice first; overrides only apply to explicit operand references.
    function automatic seg_e pick_seg(input ref_e kind, input logic [IDX_W-1:0] ovr);
        seg_e s;
        unique case (kind)
            REF_FETCH:   s = SEG_CS;
            REF_PUSHPOP: s = SEG_SS;
            REF_STKDATA: s = ovr_usable(ovr) ? seg_e'(ovr) : SEG_SS;
            default:     s = ovr_usable(ovr) ? seg_e'(ovr) : SEG_DS;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/seg_selector.sv
module seg_selector
    import seg_pkg::*;
(
    input  ref_e                 kind,
    input  logic [IDX_W-1:0]     ovr,
    output seg_e                 seg
);

    always_comb begin
        seg = pick_seg(kind, ovr);
    end

    // Fixed-segment kinds must never land outside CS/SS.
    always_comb begin
        if (kind == REF_FETCH)
            assert_sel_fetch_R4: assert (seg == SEG_CS) else $error("fetch not CS");
        if (kind == REF_PUSHPOP)
            assert_sel_push_R3: assert (seg == SEG_SS) else $error("push/pop not SS");
    end

endmodule

// File: rtl/seg_base_file.sv
module seg_base_file
    import seg_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int NSEG  = NUM_SEGS,
    parameter int IW    = IDX_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [IW-1:0]   wr_idx,
    input  logic [AW-1:0]   wr_data,
    input  logic [IW-1:0]   rd_idx,
    output logic [AW-1:0]   rd_data
);

    localparam logic [IW-1:0] LAST_IDX = IW'(NSEG - 1);

    logic [AW-1:0] base_q [NSEG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSEG; i++) base_q[i] <= '0;
        end else if (wr_en && wr_idx <= LAST_IDX) begin
            base_q[wr_idx] <= wr_data;
        end
    end

    // Read side sees the register contents before any same-cycle write.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (rd_idx == IW'(i)) rd_data = base_q[i];
        end
    end

    assert_wr_take_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx <= LAST_IDX) |=> base_q[$past(wr_idx)] == $past(wr_data));

    assert_wr_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_idx <= LAST_IDX) |=> $stable(rd_data) || $changed(rd_idx));

endmodule

// File: rtl/seg_addr_stage.sv
module seg_addr_stage
    import seg_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  seg_e            in_seg,
    input  logic [AW-1:0]   in_base,
    input  logic [AW-1:0]   in_offset,
    output addr_res_t       res
);

    logic [AW-1:0] sum;

    // Carry out is discarded: addresses wrap at 2^AW.
    always_comb begin
        sum = in_base + in_offset;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '{valid: 1'b0, seg: SEG_ES, base: '0, linear: '0};
        end else begin
            res.valid <= in_valid;
            if (in_valid) begin
                res.seg    <= in_seg;
                res.base   <= in_base;
                res.linear <= sum;
            end
        end
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(res.linear) && $stable(res.seg) && $stable(res.base));

endmodule

// File: rtl/seg_linear_unit.sv
module seg_linear_unit
    import seg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    input  logic [1:0]   req_kind,
    input  logic [2:0]   req_ovr,
    input  logic [31:0]  req_offset,
    input  logic         wr_en,
    input  logic [2:0]   wr_idx,
    input  logic [31:0]  wr_base,
    output logic         out_valid,
    output logic [2:0]   out_seg,
    output logic [31:0]  out_base,
    output logic [31:0]  out_linear
);

    seg_e          sel_seg;
    logic [31:0]   sel_base;
    addr_res_t     res;

    seg_selector u_sel (
        .kind (ref_e'(req_kind)),
        .ovr  (req_ovr),
        .seg  (sel_seg)
    );

    seg_base_file #(.AW(ADDR_W), .NSEG(NUM_SEGS), .IW(IDX_W)) u_bases (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_base),
        .rd_idx  (sel_seg),
        .rd_data (sel_base)
    );

    seg_addr_stage #(.AW(ADDR_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (req_valid),
        .in_seg    (sel_seg),
        .in_base   (sel_base),
        .in_offset (req_offset),
        .res       (res)
    );

    assign out_valid  = res.valid;
    assign out_seg    = res.seg;
    assign out_base   = res.base;
    assign out_linear = res.linear;

    assert_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    assert_fetch_cs_R4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd2) |=> out_seg == 3'd1);

    assert_push_ss_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd1) |=> out_seg == 3'd2);

    assert_data_ds_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_kind == 2'd0 && req_ovr >= 3'd6) |=> out_seg == 3'd3);

    assert_sum_R7: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_linear == out_base + $past(req_offset));

endmodule

// File: tb/seg_linear_unit_tb.sv
`timescale 1ns/1ps
module seg_linear_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic [1:0]   req_kind = '0;
    logic [2:0]   req_ovr = 3'd7;
    logic [31:0]  req_offset = '0;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_idx = '0;
    logic [31:0]  wr_base = '0;
    logic         out_valid;
    logic [2:0]   out_seg;
    logic [31:0]  out_base;
    logic [31:0]  out_linear;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] mbase [6];

    always #2.5 clk = ~clk;

    seg_linear_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_ovr(req_ovr), .req_offset(req_offset), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_base(wr_base), .out_valid(out_valid),
        .out_seg(out_seg), .out_base(out_base), .out_linear(out_linear)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [2:0] model_seg(input logic [1:0] k, input logic [2:0] o);
        if (k == 2'd2) return 3'd1;
        if (k == 2'd1) return 3'd2;
        if (o < 3'd6) return o;
        if (k == 2'd3) return 3'd2;
        return 3'd3;
    endfunction

    // One request, optionally with a write in the same cycle; checked a cycle later.
    task automatic issue(input logic [1:0] k, input logic [2:0] o, input logic [31:0] off,
                         input logic we, input logic [2:0] wi, input logic [31:0] wd,
                         input string rq);
        logic [2:0]  es;
        logic [31:0] eb;
        es = model_seg(k, o);
        eb = mbase[es];
        req_valid = 1'b1; req_kind = k; req_ovr = o; req_offset = off;
        wr_en = we; wr_idx = wi; wr_base = wd;
        @(negedge clk);
        req_valid = 1'b0; wr_en = 1'b0;
        if (we && wi < 3'd6) mbase[wi] = wd;
        chk({rq, " R8 valid"}, {31'd0, out_valid}, 32'd1);
        chk({rq, " seg"}, {29'd0, out_seg}, {29'd0, es});
        chk({rq, " base"}, out_base, eb);
        chk({rq, " R7 linear"}, out_linear, eb + off);
    endtask

    task automatic write_only(input logic [2:0] wi, input logic [31:0] wd);
        wr_en = 1'b1; wr_idx = wi; wr_base = wd;
        @(negedge clk);
        wr_en = 1'b0;
        if (wi < 3'd6) mbase[wi] = wd;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] lin_hold;
        logic [2:0]  seg_hold;
        for (int i = 0; i < 6; i++) mbase[i] = '0;
        void'($urandom(32'h1234_abcd));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset valid", {31'd0, out_valid}, 32'd0);

        // R1 / R10: flat mode on every segment, including the wrap edge
        for (int s = 0; s < 6; s++) issue(2'd0, 3'(s), 32'hFFFF_FFF0 + 32'(s), 1'b0, 3'd0, 32'd0, "R1 R10 flat");
        issue(2'd2, 3'd7, 32'h0000_1000, 1'b0, 3'd0, 32'd0, "R10 flat fetch");

        // load distinct bases
        write_only(3'd0, 32'h1000_0000);
        write_only(3'd1, 32'h2000_0000);
        write_only(3'd2, 32'h3000_0000);
        write_only(3'd3, 32'h4000_0000);
        write_only(3'd4, 32'h5000_0000);
        write_only(3'd5, 32'hF000_0000);

        issue(2'd0, 3'd7, 32'h0000_0044, 1'b0, 3'd0, 32'd0, "R2 data default");
        issue(2'd0, 3'd6, 32'h0000_0048, 1'b0, 3'd0, 32'd0, "R6 code6 none");
        issue(2'd1, 3'd4, 32'h0000_0100, 1'b0, 3'd0, 32'd0, "R3 push ovr ignored");
        issue(2'd2, 3'd0, 32'h0000_0200, 1'b0, 3'd0, 32'd0, "R4 fetch ovr ignored");
        issue(2'd3, 3'd7, 32'h0000_0300, 1'b0, 3'd0, 32'd0, "R5 stack-rel default");
        issue(2'd3, 3'd5, 32'h0000_0304, 1'b0, 3'd0, 32'd0, "R6 stack-rel ovr GS");
        issue(2'd0, 3'd0, 32'h0000_0010, 1'b0, 3'd0, 32'd0, "R6 ovr ES");
        issue(2'd0, 3'd4, 32'h0000_0020, 1'b0, 3'd0, 32'd0, "R6 ovr FS");
        issue(2'd0, 3'd5, 32'h2000_0001, 1'b0, 3'd0, 32'd0, "R7 wrap GS");

        // R8: idle cycle holds outputs
        lin_hold = out_linear; seg_hold = out_seg;
        @(negedge clk);
        chk("R8 idle valid", {31'd0, out_valid}, 32'd0);
        chk("R8 idle hold linear", out_linear, lin_hold);
        chk("R8 idle hold seg", {29'd0, out_seg}, {29'd0, seg_hold});

        // R9: same-cycle write and read of the same segment
        issue(2'd2, 3'd7, 32'h0000_0004, 1'b1, 3'd1, 32'hAAAA_0000, "R9 collide CS old");
        issue(2'd2, 3'd7, 32'h0000_0004, 1'b0, 3'd0, 32'd0, "R9 collide CS new");
        issue(2'd1, 3'd7, 32'h0000_0008, 1'b1, 3'd2, 32'hBBBB_0000, "R9 collide SS old");
        issue(2'd1, 3'd7, 32'h0000_0008, 1'b0, 3'd0, 32'd0, "R9 collide SS new");
        issue(2'd0, 3'd4, 32'h0000_000C, 1'b1, 3'd4, 32'hCCCC_0000, "R9 collide FS old");
        issue(2'd0, 3'd4, 32'h0000_000C, 1'b0, 3'd0, 32'd0, "R9 collide FS new");

        // R9: writes to codes 6 and 7 change nothing
        write_only(3'd6, 32'hDEAD_BEEF);
        write_only(3'd7, 32'h1234_5678);
        for (int s = 0; s < 6; s++) issue(2'd0, 3'(s), 32'h0000_0001, 1'b0, 3'd0, 32'd0, "R9 bad index ignored");

        // random traffic
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  k;
            logic [2:0]  o;
            logic [2:0]  wi;
            logic        we;
            k  = 2'($urandom_range(0, 3));
            o  = 3'($urandom_range(0, 7));
            wi = 3'($urandom_range(0, 7));
            we = 1'($urandom_range(0, 1));
            issue(k, o, $urandom(), we, wi, $urandom(), "R2 R3 R4 R5 R6 R9 random");
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                chk("R8 random idle", {31'd0, out_valid}, 32'd0);
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule